// File: doc/BRIEF.md
# Complementary PWM with dead time

This block generates four edge-aligned pulse-width modulated channels for a half-bridge style power stage. Each channel drives two gate signals: a high-side output that is active during the first part of each counter period, and a low-side output that is active during the rest of it. Each of the two signals in a pair has its rising edge held back by a programmable number of clocks, so that the two switches of a leg never conduct together. Both signals have their own polarity and their own idle level.

Software programs the block through a simple write port. The period, the duty of each channel and the repetition count go into shadow registers. They are copied to the working set only at an update event. An update event happens when the counter wraps, but only once every N+1 periods, where N is the repetition count. A protection unit can assert `safe_req`. One clock later every gate sits at its idle level, and the master enable stays cleared until software writes it again.

Register map (address: content):

| Address | Content |
|---|---|
| 0 | period shadow P |
| 1 | repetition shadow N |
| 2 | dead time DT |
| 3 | polarity, 8 bits |
| 4 | idle levels, 8 bits |
| 5 | master enable, bit 0 |
| 6 | per-output enable mask, 8 bits |
| 8+i | duty shadow of channel i |

In the 8-bit fields, bit i belongs to the high-side output of channel i and bit 4+i belongs to the low-side output of channel i.

Top module: `cpwm_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it, every gate is 0 and `upd_pulse` is 0. All registers reset to 0.
- R2: With a working period P, the counter steps through 0..P-1 and then wraps, so a period lasts P clocks. A P of 0 or 1 wraps on every clock.
- R3: The raw high-side signal of channel i is active while the counter is below the working duty Di. Di=0 gives an output that is never active. Di=P (or larger) gives an output that is always active. The raw low-side signal is the inverse of the raw high-side signal.
- R4: A write to the period or duty shadows changes nothing until the next update event. At that event the working values take the shadow contents, and they never change at any other time.
- R5: A working repetition count N makes an update event occur on every (N+1)-th wrap. The repetition shadow is itself loaded into the working count at each update event.
- R6: Each output turns active DT clocks after its raw signal rises, and turns inactive at the same time as its raw signal falls. The two outputs of a pair are never active together.
- R7: When DT is at least as long as a raw active phase, the output stays inactive for the whole of that phase.
- R8: A polarity bit of 1 inverts the corresponding gate whenever that gate is driven.
- R9: When the master enable is 0, or when the mask bit of an output is 0, that gate drives its idle bit.
- R10: When `safe_req` is high in a cycle, the next clock puts every gate at its idle level and clears the master enable. The clear wins over an enable write made in the same cycle.
- R11: A gate reflects the counter value of the previous clock. `upd_pulse` is high for exactly the first clock of the period that starts with the new working values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 16 | Register write data |
| safe_req | input | 1 | Safe-state request from protection logic |
| gate_hi | output | 4 | High-side gate per channel |
| gate_lo | output | 4 | Low-side gate per channel |
| upd_pulse | output | 1 | One-clock pulse marking an update event |

## Verification
The assertions assume that `safe_req` and the write port are synchronous to `clk` and stable around its rising edge. They also assume that the period and duty values fit the counter width. The bench changes every input one nanosecond after a rising edge and holds it for the rest of the cycle. It writes only the listed addresses, with values that fit their fields. It keeps the dead time below 255, so the saturating run counter of each output never wraps. For the direct window counts, the bench lets a full period settle after each configuration change, so every window sees a steady pattern.

// File: rtl/cpwm_pkg.sv
`timescale 1ns/1ps
package cpwm_pkg;
  localparam int unsigned A_PERIOD = 0;
  localparam int unsigned A_REPEAT = 1;
  localparam int unsigned A_DEAD   = 2;
  localparam int unsigned A_POL    = 3;
  localparam int unsigned A_IDLE   = 4;
  localparam int unsigned A_ENABLE = 5;
  localparam int unsigned A_MASK   = 6;
  localparam int unsigned A_DUTY0  = 8;
endpackage

// File: rtl/cpwm_regs.sv
`timescale 1ns/1ps
module cpwm_regs #(
  parameter int NCH = 4,
  parameter int CW  = 16,
  parameter int RW  = 8,
  parameter int DTW = 8,
  parameter int AW  = 4,
  localparam int OW = 2 * NCH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [CW-1:0]     wdata,
  input  logic              safe_req,
  output logic [CW-1:0]     per_sh,
  output logic [RW-1:0]     rep_sh,
  output logic [DTW-1:0]    dead,
  output logic [OW-1:0]     pol,
  output logic [OW-1:0]     idle,
  output logic              en,
  output logic [OW-1:0]     mask,
  output logic [NCH*CW-1:0] duty_sh
);
  import cpwm_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      per_sh <= '0;
      rep_sh <= '0;
      dead   <= '0;
      pol    <= '0;
      idle   <= '0;
      en     <= 1'b0;
      mask   <= '0;
    end else begin
      if (we) begin
        if (addr == AW'(A_PERIOD)) per_sh <= wdata;
        if (addr == AW'(A_REPEAT)) rep_sh <= wdata[RW-1:0];
        if (addr == AW'(A_DEAD))   dead   <= wdata[DTW-1:0];
        if (addr == AW'(A_POL))    pol    <= wdata[OW-1:0];
        if (addr == AW'(A_IDLE))   idle   <= wdata[OW-1:0];
        if (addr == AW'(A_ENABLE)) en     <= wdata[0];
        if (addr == AW'(A_MASK))   mask   <= wdata[OW-1:0];
      end
      if (safe_req) en <= 1'b0;  // protection wins over software
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_duty
    always_ff @(posedge clk) begin
      if (rst)
        duty_sh[i*CW +: CW] <= '0;
      else if (we && addr == AW'(A_DUTY0 + i))
        duty_sh[i*CW +: CW] <= wdata;
    end
  end
endmodule

// File: rtl/cpwm_timebase.sv
`timescale 1ns/1ps
module cpwm_timebase #(
  parameter int CW = 16,
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] per_sh,
  input  logic [RW-1:0] rep_sh,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] per_act,
  output logic          upd_now,
  output logic          upd_pulse
);
  logic [RW-1:0] rep_left;
  logic [CW:0]   cnt_inc;
  logic          wrap;

  assign cnt_inc = {1'b0, cnt} + 1'b1;
  assign wrap    = cnt_inc >= {1'b0, per_act};
  assign upd_now = wrap && (rep_left == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      per_act   <= '0;
      rep_left  <= '0;
      upd_pulse <= 1'b0;
    end else begin
      cnt       <= wrap ? '0 : cnt_inc[CW-1:0];
      upd_pulse <= upd_now;
      if (upd_now) begin
        per_act  <= per_sh;
        rep_left <= rep_sh;
      end else if (wrap) begin
        rep_left <= rep_left - 1'b1;
      end
    end
  end
endmodule

// File: rtl/cpwm_deadband.sv
`timescale 1ns/1ps
module cpwm_deadband #(
  parameter int DTW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           raw,
  input  logic [DTW-1:0] dead,
  output logic           qual
);
  logic [DTW-1:0] run;

  // counts clocks since raw rose, saturating at the dead time
  always_ff @(posedge clk) begin
    if (rst || !raw)   run <= '0;
    else if (run < dead) run <= run + 1'b1;
  end

  assign qual = raw && (run >= dead);
endmodule

// File: rtl/cpwm_top.sv
`timescale 1ns/1ps
module cpwm_top #(
  parameter int NCH = 4,
  parameter int CW  = 16,
  parameter int RW  = 8,
  parameter int DTW = 8,
  parameter int AW  = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_we,
  input  logic [AW-1:0]  cfg_addr,
  input  logic [CW-1:0]  cfg_wdata,
  input  logic           safe_req,
  output logic [NCH-1:0] gate_hi,
  output logic [NCH-1:0] gate_lo,
  output logic           upd_pulse
);
  localparam int OW = 2 * NCH;

  logic [CW-1:0]     per_sh, per_act, cnt_w;
  logic [RW-1:0]     rep_sh;
  logic [DTW-1:0]    dead_q;
  logic [OW-1:0]     pol_q, idle_q, mask_q;
  logic              en_q, upd_now;
  logic [NCH*CW-1:0] duty_sh;
  logic [CW-1:0]     duty_act [NCH];
  logic [OW-1:0]     raw, qual, drive, gate_q;
  logic [NCH-1:0]    act_hi_q, act_lo_q;

  cpwm_regs #(.NCH(NCH), .CW(CW), .RW(RW), .DTW(DTW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .safe_req(safe_req), .per_sh(per_sh), .rep_sh(rep_sh), .dead(dead_q),
    .pol(pol_q), .idle(idle_q), .en(en_q), .mask(mask_q), .duty_sh(duty_sh)
  );

  cpwm_timebase #(.CW(CW), .RW(RW)) u_tb (
    .clk(clk), .rst(rst), .per_sh(per_sh), .rep_sh(rep_sh), .cnt(cnt_w),
    .per_act(per_act), .upd_now(upd_now), .upd_pulse(upd_pulse)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst)          duty_act[i] <= '0;
      else if (upd_now) duty_act[i] <= duty_sh[i*CW +: CW];
    end
    assign raw[i]       = cnt_w < duty_act[i];
    assign raw[NCH + i] = ~raw[i];
  end

  for (genvar k = 0; k < OW; k++) begin : g_db
    cpwm_deadband #(.DTW(DTW)) u_db (
      .clk(clk), .rst(rst), .raw(raw[k]), .dead(dead_q), .qual(qual[k])
    );
  end

  assign drive = {OW{en_q & ~safe_req}} & mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q   <= '0;
      act_hi_q <= '0;
      act_lo_q <= '0;
    end else begin
      gate_q   <= (drive & (qual ^ pol_q)) | (~drive & idle_q);
      act_hi_q <= qual[NCH-1:0];
      act_lo_q <= qual[OW-1:NCH];
    end
  end

  assign gate_hi = gate_q[NCH-1:0];
  assign gate_lo = gate_q[OW-1:NCH];
endmodule

// File: rtl/cpwm_checker.sv
`timescale 1ns/1ps
module cpwm_checker #(
  parameter int NCH = 4,
  parameter int CW  = 16,
  localparam int OW = 2 * NCH
) (
  input logic           clk,
  input logic           rst,
  input logic           safe_req,
  input logic           en,
  input logic           upd_pulse,
  input logic [CW-1:0]  cnt,
  input logic [CW-1:0]  per_act,
  input logic [NCH-1:0] act_hi,
  input logic [NCH-1:0] act_lo,
  input logic [OW-1:0]  gate,
  input logic [OW-1:0]  idle
);
  // R2: counter stays inside the working period
  a_r2_cnt_in_period: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0) || (cnt < per_act));

  // R4: working period moves only together with an update event
  a_r4_period_at_update: assert property (@(posedge clk) disable iff (rst)
    (per_act != $past(per_act)) |-> upd_pulse);

  // R11: update pulse marks the first clock of a period
  a_r11_pulse_at_zero: assert property (@(posedge clk) disable iff (rst)
    upd_pulse |-> (cnt == '0));

  // R6: no leg has both switches active
  a_r6_pair_exclusive: assert property (@(posedge clk) disable iff (rst)
    (act_hi & act_lo) == '0);

  // R10: safe request idles every gate on the next clock
  a_r10_safe_idles: assert property (@(posedge clk) disable iff (rst)
    safe_req |=> (gate == $past(idle)));

  // R10: safe request clears the master enable
  a_r10_enable_cleared: assert property (@(posedge clk) disable iff (rst)
    safe_req |=> !en);

  // R9: master enable off means idle levels
  a_r9_disabled_idles: assert property (@(posedge clk) disable iff (rst)
    !en |=> (gate == $past(idle)));
endmodule

bind cpwm_top cpwm_checker #(.NCH(NCH), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .safe_req(safe_req), .en(en_q),
  .upd_pulse(upd_pulse), .cnt(cnt_w), .per_act(per_act),
  .act_hi(act_hi_q), .act_lo(act_lo_q), .gate(gate_q), .idle(idle_q)
);

// File: tb/test_cpwm_top.sv
`timescale 1ns/1ps
module test_cpwm_top;
  localparam int NCH = 4;
  localparam int OW  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic safe_req = 1'b0;
  logic [NCH-1:0] gate_hi, gate_lo;
  logic upd_pulse;

  always #2 clk = ~clk;

  cpwm_top i_cpwm_top (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .safe_req(safe_req), .gate_hi(gate_hi),
    .gate_lo(gate_lo), .upd_pulse(upd_pulse)
  );

  int vectors = 0;
  int miscompares = 0;
  string cur_req = "R1";

  // behavioural reference state
  int mcnt, mrep, mper, mpersh, mrepsh, mdt;
  int mdsh[NCH];
  int mdact[NCH];
  int mrun[OW];
  logic [OW-1:0] mpol, midle, mmask, egate;
  bit men, eupd;

  task automatic model_reset();
    mcnt = 0; mrep = 0; mper = 0; mpersh = 0; mrepsh = 0; mdt = 0;
    for (int i = 0; i < NCH; i++) begin mdsh[i] = 0; mdact[i] = 0; end
    for (int k = 0; k < OW; k++) mrun[k] = 0;
    mpol = '0; midle = '0; mmask = '0; men = 0; egate = '0; eupd = 0;
  endtask

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one clock: drive inputs, predict, advance, compare
  task automatic step(input bit we, input int addr, input int data, input bit safe);
    bit wrap, updnow, rawm, raw, qual, drv;
    cfg_we = we; cfg_addr = addr[3:0]; cfg_wdata = data[15:0]; safe_req = safe;
    wrap = (mcnt + 1 >= mper);
    updnow = wrap && (mrep == 0);
    for (int k = 0; k < OW; k++) begin
      rawm = mcnt < mdact[k % NCH];
      raw  = (k < NCH) ? rawm : !rawm;
      qual = raw && (mrun[k] >= mdt);
      drv  = men && !safe && mmask[k];
      egate[k] = drv ? (qual ^ mpol[k]) : midle[k];
      mrun[k] = raw ? ((mrun[k] < mdt) ? mrun[k] + 1 : mrun[k]) : 0;
    end
    eupd = updnow;
    if (updnow) begin
      for (int i = 0; i < NCH; i++) mdact[i] = mdsh[i];
      mper = mpersh; mrep = mrepsh;
    end else if (wrap) mrep = mrep - 1;
    mcnt = wrap ? 0 : mcnt + 1;
    if (we) begin
      case (addr)
        0: mpersh = data & 16'hFFFF;
        1: mrepsh = data & 8'hFF;
        2: mdt = data & 8'hFF;
        3: mpol = data[7:0];
        4: midle = data[7:0];
        5: men = data[0];
        6: mmask = data[7:0];
        default: if (addr >= 8 && addr < 8 + NCH) mdsh[addr - 8] = data & 16'hFFFF;
      endcase
    end
    if (safe) men = 0;
    @(posedge clk); #1;
    cfg_we = 1'b0; safe_req = 1'b0;
    vectors++;
    if ({gate_lo, gate_hi} !== egate || upd_pulse !== eupd) begin
      miscompares++;
      $display("FAIL %s: gates=%h upd=%b expected gates=%h upd=%b",
               cur_req, {gate_lo, gate_hi}, upd_pulse, egate, eupd);
    end
  endtask

  task automatic wr(input int addr, input int data);
    step(1, addr, data, 0);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0);
  endtask

  initial begin
    #(4 * 150000);
    miscompares++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  int cnt_a, cnt_b;

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    check("R1 gates in reset", {gate_lo, gate_hi}, 0);
    check("R1 pulse in reset", upd_pulse, 0);
    rst = 1'b0;

    cur_req = "R2";
    run(2);
    wr(0, 8);
    wr(8, 3); wr(9, 0); wr(10, 8); wr(11, 5);
    wr(6, 8'hFF);
    wr(5, 1);
    run(24);

    cur_req = "R3";
    cnt_a = 0; cnt_b = 0;
    for (int i = 0; i < 8; i++) begin
      step(0, 0, 0, 0);
      cnt_a += gate_hi[0];
      cnt_b += gate_hi[2] + gate_hi[1];
    end
    check("R3 duty 3 of 8 active clocks", cnt_a, 3);
    check("R3 duty 8 full and duty 0 none", cnt_b, 8);

    cur_req = "R4";
    run(3);
    wr(0, 5);
    wr(8, 1);
    run(30);

    cur_req = "R5";
    wr(1, 2);
    cnt_a = 0;
    run(10);
    for (int i = 0; i < 30; i++) begin
      step(0, 0, 0, 0);
      cnt_a += upd_pulse;
    end
    check("R5 one update per 15 clocks", cnt_a, 2);
    wr(1, 0);
    run(20);

    cur_req = "R6";
    wr(0, 8); wr(8, 3); wr(11, 5);
    run(10);
    wr(2, 2);
    run(30);

    cur_req = "R7";
    wr(2, 4);
    run(16);
    cnt_a = 0; cnt_b = 0;
    for (int i = 0; i < 16; i++) begin
      step(0, 0, 0, 0);
      cnt_a += gate_hi[0];
      cnt_b += gate_lo[0];
    end
    check("R7 high side hidden by dead time", cnt_a, 0);
    check("R7 low side one clock per period", cnt_b, 2);
    wr(2, 0);
    run(10);

    cur_req = "R8";
    wr(3, 8'hA5);
    run(20);
    wr(3, 8'h00);

    cur_req = "R9";
    wr(4, 8'h3C);
    wr(6, 8'h0F);
    run(12);
    wr(5, 0);
    run(12);
    check("R9 idle levels while disabled", {gate_lo, gate_hi}, 8'h3C);

    cur_req = "R10";
    wr(5, 1);
    wr(6, 8'hFF);
    run(10);
    step(0, 0, 0, 1);
    check("R10 idle after safe request", {gate_lo, gate_hi}, 8'h3C);
    run(8);
    wr(5, 1);
    run(6);
    step(1, 5, 1, 1);
    run(10);
    check("R10 clear beats enable write", {gate_lo, gate_hi}, 8'h3C);
    wr(5, 1);

    cur_req = "R11";
    wr(0, 1); wr(8, 1);
    run(12);
    wr(0, 6); wr(9, 6); wr(10, 2);
    run(30);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule